// File: doc/BRIEF.md
# Interleaved Memory Window Target Decoder

This block steers host memory accesses that land in one fixed memory window toward a downstream root port. It does so in two steps. First, the window offset of a request is turned into an absolute host address by adding the window base. A window-level interleave then picks one of several host bridges from that address. Second, the chosen bridge's own decoder must be committed. When it is, a second interleave over that decoder's granularity and way count picks a byte from an eight-entry, byte-packed target list. That byte is the port number.

Configuration arrives over a plain register write port. Each request gives an offset, a read/write flag and a byte count, and one cycle later the block returns a response. The response carries a hit flag, the bridge index, the port number and an error flag. A miss is treated differently for reads and writes: a read that finds no target reports an error, with zero data implied on the data path outside this block. A write that finds no target is dropped quietly and reports success.

Register map (word addresses on `cfgAddr`, fields in `cfgData`):
- 0: window granularity encoding in bits [2:0]. Granularity is 256 << enc bytes; valid for enc 0..6; reset value 0.
- 1: window base, in 1 MiB units.
- 2: window size, in 1 MiB units.
- 3: window target count in bits [3:0]; valid for 1..NUM_BRIDGES; reset value 1.
- 8 + 4*b + 0: bridge b decoder control. Bits [2:0] are the granularity encoding (256 << enc bytes, 0..6). Bits [6:4] are the ways encoding (2^enc ways, 0..3). Bit [8] is the committed flag.
- 8 + 4*b + 1: bridge b target entries 0..3. Entry i is in bits [8i+7:8i].
- 8 + 4*b + 2: bridge b target entries 4..7. Entry i is in bits [8(i-4)+7:8(i-4)].

Top module: `imw_target_decoder`

## Requirements
- R1: The absolute address equals the request offset plus the window base times 2^20. The bridge index is (absolute address >> (8 + window granularity encoding)) modulo the window target count.
- R2: After reset the window granularity encoding is 0, which means 256-byte interleave, until register 0 is written.
- R3: A window size write whose bits [7:0] are not all zero is not a multiple of 256 MiB, so it is ignored and the previous size stays. A request whose offset is at or beyond size times 2^20 is a miss.
- R4: A bridge decoder whose control bit 8 (committed) is clear makes every access routed to that bridge a miss.
- R5: The target index is (absolute address >> (8 + bridge granularity encoding)) modulo 2^(bridge ways encoding).
- R6: Target index i selects byte i of the entry 0..3 register when i is 0..3. It selects byte i-4 of the entry 4..7 register when i is 4..7. The selected byte is output as `rspPort`.
- R7: A read that misses returns `rspErr`=1 and `rspHit`=0. A read that hits returns `rspErr`=0.
- R8: A write that misses returns `rspHit`=0 and `rspErr`=0. A write never returns `rspErr`=1.
- R9: Byte counts from 1 to 8 are decoded at any alignment, using the starting offset. A count of 0 or above 8 is a miss.
- R10: Every request produces exactly one response, with `rspValid` high in the cycle after the request. When `rspValid` is low, `rspHit` and `rspErr` are 0.
- R11: Any of these makes a request a miss: window granularity encoding 7, target count 0 or above NUM_BRIDGES, bridge granularity encoding 7, or bridge ways encoding above 3. On any miss, `rspBridge` and `rspPort` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration word address |
| cfgData | input | 32 | Configuration write data |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | ADDR_W | Offset of the access within the window |
| reqSize | input | 4 | Access length in bytes |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | A valid target was found |
| rspErr | output | 1 | Error response (read miss) |
| rspBridge | output | BR_W | Selected host bridge index |
| rspPort | output | 8 | Selected root port number |

## Verification
The hardest case to reach is a second-level index that crosses from the low target register into the high one on a bridge that the first level actually selects. Both interleave levels depend on the same absolute address, with the base folded in. The stimulus gives every bridge a list of distinct bytes and sweeps offsets with an odd stride. It does this under several pairs of granularity and ways settings, so each list byte is reached through each bridge. It then uncommits one bridge and sends reads and writes to it, to show the two miss responses.

// File: rtl/imw_pkg.sv
package imw_pkg;
  localparam int MIB_SHIFT = 20;
  localparam int GRAN_BASE = 8;
  localparam int GRAN_MAX  = 6;
  localparam int WAYS_MAX  = 3;
  localparam int SEL_W     = 4;
  localparam int BR_REG_BASE = 8;

  typedef struct packed {
    logic             winGranWr;
    logic             winBaseWr;
    logic             winSizeWr;
    logic             winCountWr;
    logic             brCtrlWr;
    logic             brLoWr;
    logic             brHiWr;
    logic [SEL_W-1:0] brSel;
    logic             reqTake;
    logic             reqWrite;
  } strobe_t;
endpackage

// File: rtl/imw_dec_ctrl.sv
module imw_dec_ctrl
  import imw_pkg::*;
#(
  parameter int NUM_BRIDGES = 4,
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic              reqWrite,
  output strobe_t           strb,
  output logic              rspValid
);
  logic [CFG_AW-1:0] brOff;

  always_comb begin
    strb = '0;
    brOff = cfgAddr - CFG_AW'(BR_REG_BASE);
    strb.reqTake = reqValid;
    strb.reqWrite = reqWrite;
    if (cfgWrEn) begin
      if (32'(cfgAddr) >= BR_REG_BASE && 32'(brOff) < NUM_BRIDGES * 4) begin
        strb.brSel = SEL_W'(brOff >> 2);
        strb.brCtrlWr = (brOff[1:0] == 2'd0);
        strb.brLoWr = (brOff[1:0] == 2'd1);
        strb.brHiWr = (brOff[1:0] == 2'd2);
      end else begin
        strb.winGranWr = (32'(cfgAddr) == 0);
        strb.winBaseWr = (32'(cfgAddr) == 1);
        // sizes must be whole multiples of 256 MiB
        strb.winSizeWr = (32'(cfgAddr) == 2) && (cfgData[7:0] == 8'd0);
        strb.winCountWr = (32'(cfgAddr) == 3);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else rspValid <= reqValid;
  end

  assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/imw_dec_path.sv
module imw_dec_path
  import imw_pkg::*;
#(
  parameter int NUM_BRIDGES = 4,
  parameter int ADDR_W = 52,
  parameter int BR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [3:0]        reqSize,
  output logic              rspHit,
  output logic              rspErr,
  output logic [BR_W-1:0]   rspBridge,
  output logic [7:0]        rspPort
);
  localparam int SPAN_W = 32 + MIB_SHIFT;

  logic [2:0]  winGran;
  logic [31:0] winBase;
  logic [31:0] winSize;
  logic [3:0]  winCount;
  logic [2:0]  brGran [NUM_BRIDGES];
  logic [2:0]  brWays [NUM_BRIDGES];
  logic        brCommit [NUM_BRIDGES];
  logic [31:0] brLo [NUM_BRIDGES];
  logic [31:0] brHi [NUM_BRIDGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winGran <= '0;
      winBase <= '0;
      winSize <= '0;
      winCount <= 4'd1;
    end else begin
      if (strb.winGranWr) winGran <= cfgData[2:0];
      if (strb.winBaseWr) winBase <= cfgData;
      if (strb.winSizeWr) winSize <= cfgData;
      if (strb.winCountWr) winCount <= cfgData[3:0];
    end
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    always_ff @(posedge clk) begin
      if (!rstN) begin
        brGran[b] <= '0;
        brWays[b] <= '0;
        brCommit[b] <= 1'b0;
        brLo[b] <= '0;
        brHi[b] <= '0;
      end else if (32'(strb.brSel) == b) begin
        if (strb.brCtrlWr) begin
          brGran[b] <= cfgData[2:0];
          brWays[b] <= cfgData[6:4];
          brCommit[b] <= cfgData[8];
        end
        if (strb.brLoWr) brLo[b] <= cfgData;
        if (strb.brHiWr) brHi[b] <= cfgData;
      end
    end
  end

  logic [ADDR_W-1:0] hostAddr, winQuot, winDiv, brQuot;
  logic [BR_W-1:0]   winIdx;
  logic [2:0]        subIdx;
  logic [31:0]       listWord;
  logic [7:0]        portSel;
  logic              countOk, winOk, brOk, sizeOk, inRange, hitC;

  always_comb begin
    hostAddr = reqOffset + ADDR_W'({winBase, {MIB_SHIFT{1'b0}}});
    inRange  = SPAN_W'(reqOffset) < {winSize, {MIB_SHIFT{1'b0}}};
    countOk  = (winCount != 4'd0) && (32'(winCount) <= NUM_BRIDGES);
    winOk    = countOk && (32'(winGran) <= GRAN_MAX);
    sizeOk   = (reqSize != 4'd0) && (reqSize <= 4'd8);
    winDiv   = countOk ? ADDR_W'(winCount) : ADDR_W'(1);
    winQuot  = hostAddr >> (GRAN_BASE + 32'(winGran));
    winIdx   = BR_W'(winQuot % winDiv);
    brQuot   = hostAddr >> (GRAN_BASE + 32'(brGran[winIdx]));
    subIdx   = brQuot[2:0] & 3'((4'd1 << brWays[winIdx]) - 4'd1);
    listWord = subIdx[2] ? brHi[winIdx] : brLo[winIdx];
    portSel  = 8'(listWord >> {subIdx[1:0], 3'b000});
    brOk     = brCommit[winIdx] && (32'(brWays[winIdx]) <= WAYS_MAX)
               && (32'(brGran[winIdx]) <= GRAN_MAX);
    hitC     = sizeOk && inRange && winOk && brOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.reqTake) begin
      rspHit <= 1'b0;
      rspErr <= 1'b0;
      rspBridge <= '0;
      rspPort <= '0;
    end else begin
      rspHit <= hitC;
      rspErr <= !hitC && !strb.reqWrite;
      rspBridge <= hitC ? winIdx : '0;
      rspPort <= hitC ? portSel : '0;
    end
  end

  assert_size_multiple_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.winSizeWr |-> (cfgData[7:0] == 8'd0));
  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspBridge == '0) && (rspPort == '0));
  assert_hit_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reqTake |=> !rspHit && !rspErr);
endmodule

// File: rtl/imw_target_decoder.sv
module imw_target_decoder
  import imw_pkg::*;
#(
  parameter int NUM_BRIDGES = 4,
  parameter int ADDR_W = 52,
  parameter int CFG_AW = $clog2(BR_REG_BASE + 4 * NUM_BRIDGES),
  parameter int BR_W = (NUM_BRIDGES > 1) ? $clog2(NUM_BRIDGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [3:0]        reqSize,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [BR_W-1:0]   rspBridge,
  output logic [7:0]        rspPort
);
  strobe_t strb;

  imw_dec_ctrl #(.NUM_BRIDGES(NUM_BRIDGES), .CFG_AW(CFG_AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .reqValid(reqValid), .reqWrite(reqWrite),
    .strb(strb), .rspValid(rspValid)
  );

  imw_dec_path #(.NUM_BRIDGES(NUM_BRIDGES), .ADDR_W(ADDR_W), .BR_W(BR_W)) path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgData(cfgData),
    .reqOffset(reqOffset), .reqSize(reqSize), .rspHit(rspHit),
    .rspErr(rspErr), .rspBridge(rspBridge), .rspPort(rspPort)
  );

  assert_read_resolves_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> (rspHit != rspErr));
  assert_write_never_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite |=> !rspErr);
  assert_hit_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rspHit && rspErr));
endmodule

// File: tb/imw_target_decoder_tb_top.sv
module imw_target_decoder_tb_top;
  localparam int NB = 4;
  localparam int AW = 52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqOffset = '0;
  logic [3:0] reqSize = '0;
  logic rspValid, rspHit, rspErr;
  logic [1:0] rspBridge;
  logic [7:0] rspPort;

  always #2.5 clk = ~clk;

  imw_target_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .rspValid(rspValid),
    .rspHit(rspHit), .rspErr(rspErr), .rspBridge(rspBridge), .rspPort(rspPort)
  );

  typedef struct {
    bit hit; bit err; int bridge; int port; longint due; string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit done = 0;

  // configuration mirror, updated only as the requirements allow
  int mGran = 0, mCount = 1;
  longint mBase = 0, mSize = 0;
  int mCtrl [NB];
  longint mLo [NB], mHi [NB];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(int addr, longint data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 5'(addr); cfgData = 32'(data);
    if (addr == 0) mGran = int'(data & 7);
    if (addr == 1) mBase = data & 64'hFFFF_FFFF;
    if (addr == 2 && (data & 255) == 0) mSize = data & 64'hFFFF_FFFF;
    if (addr == 3) mCount = int'(data & 15);
    if (addr >= 8 && addr < 8 + 4 * NB) begin
      if ((addr - 8) % 4 == 0) mCtrl[(addr - 8) / 4] = int'(data);
      if ((addr - 8) % 4 == 1) mLo[(addr - 8) / 4] = data & 64'hFFFF_FFFF;
      if ((addr - 8) % 4 == 2) mHi[(addr - 8) / 4] = data & 64'hFFFF_FFFF;
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic exp_t model(longint off, bit wr, int sz);
    exp_t e;
    longint hpa;
    int b, g, w, s;
    e.hit = 1; e.bridge = 0; e.port = 0;
    if (sz < 1 || sz > 8) e.hit = 0;
    if (off >= (mSize << 20)) e.hit = 0;
    if (mCount < 1 || mCount > NB) e.hit = 0;
    if (mGran > 6) e.hit = 0;
    hpa = (off + (mBase << 20)) & ((64'd1 << AW) - 1);
    b = (mCount >= 1 && mCount <= NB) ? int'((hpa >> (8 + mGran)) % mCount) : 0;
    g = mCtrl[b] & 7; w = (mCtrl[b] >> 4) & 7;
    if (((mCtrl[b] >> 8) & 1) == 0 || w > 3 || g > 6) e.hit = 0;
    s = int'((hpa >> (8 + g)) & ((64'd1 << w) - 1));
    if (e.hit) begin
      e.bridge = b;
      e.port = (s < 4) ? int'((mLo[b] >> (s * 8)) & 255) : int'((mHi[b] >> ((s - 4) * 8)) & 255);
    end
    e.err = !e.hit && !wr;
    return e;
  endfunction

  task automatic issue(longint off, bit wr, int sz, string tag);
    exp_t e;
    @(negedge clk);
    e = model(off, wr, sz);
    e.due = cyc + 1;
    e.tag = tag;
    expQ.push_back(e);
    reqValid = 1'b1; reqWrite = wr; reqOffset = AW'(off); reqSize = 4'(sz);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compares each response against the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0 && expQ[0].due <= cyc) begin
        exp_t e;
        e = expQ.pop_front();
        check(rspValid == 1'b1, e.tag, "rspValid", rspValid, 1);
        check(rspHit == e.hit && rspErr == e.err && int'(rspBridge) == e.bridge
              && int'(rspPort) == e.port, e.tag, "hit/err/bridge/port",
              {rspHit, rspErr, 6'(rspBridge), rspPort},
              {e.hit, e.err, 6'(e.bridge), 8'(e.port)});
      end else if (rstN && rspValid) begin
        check(1'b0, "R10", "unexpected rspValid", 1, 0);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mCtrl[b] = 0; mLo[b] = 0; mHi[b] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!rspValid && !rspHit && !rspErr, "R10", "reset outputs", {rspValid, rspHit, rspErr}, 0);

    // window: base 0x100 MiB, size 1 GiB, 3 targets, granularity left at reset (R2)
    cfgWrite(1, 32'h100);
    cfgWrite(2, 32'h400);
    cfgWrite(3, 3);
    for (int b = 0; b < NB; b++) begin
      cfgWrite(8 + 4 * b, 32'h130);  // committed, 8 ways, 256 B
      cfgWrite(9 + 4 * b, {8'(16 * b + 4), 8'(16 * b + 3), 8'(16 * b + 2), 8'(16 * b + 1)});
      cfgWrite(10 + 4 * b, {8'(16 * b + 8), 8'(16 * b + 7), 8'(16 * b + 6), 8'(16 * b + 5)});
    end
    for (int k = 0; k < 40; k++) issue(longint'(k) * 64'h1f3, k[0], 4, "R1 R2 R5 R6");

    // window granularity 1 KiB, bridge 1 with 4 ways at 512 B, bridge 2 with 1 way
    cfgWrite(0, 2);
    cfgWrite(12, 32'h121);
    cfgWrite(16, 32'h100);
    for (int k = 0; k < 40; k++) issue(longint'(k) * 64'h2e7 + 5, 1'b0, 2, "R1 R5 R6");

    // four targets
    cfgWrite(3, 4);
    for (int k = 0; k < 24; k++) issue(longint'(k) * 64'h3c1, 1'b1, 8, "R1 R6");

    // uncommit bridge 1: reads error, writes silent
    cfgWrite(12, 32'h021);
    for (int k = 0; k < 16; k++) issue(longint'(k) * 64'h400, 1'b0, 1, "R4 R7");
    for (int k = 0; k < 16; k++) issue(longint'(k) * 64'h400, 1'b1, 1, "R4 R8");
    cfgWrite(12, 32'h121);

    // size bounds and rejected size write
    issue(64'h3FFF_FFF0, 1'b0, 8, "R3 in range");
    issue(64'h4000_0000, 1'b0, 4, "R3 beyond");
    cfgWrite(2, 32'h4A0);
    issue(64'h4000_0000, 1'b0, 4, "R3 rejected size");
    issue(64'h4000_0000, 1'b1, 4, "R3 R8 beyond write");

    // byte counts and alignment
    issue(64'h1237, 1'b0, 8, "R9 unaligned 8");
    issue(64'h1237, 1'b0, 0, "R9 size 0");
    issue(64'h1237, 1'b0, 9, "R9 size 9");
    issue(64'h1001, 1'b1, 3, "R9 unaligned 3");

    // invalid encodings
    cfgWrite(3, 0);
    issue(64'h800, 1'b0, 4, "R11 count 0");
    cfgWrite(3, 5);
    issue(64'h800, 1'b0, 4, "R11 count above max");
    cfgWrite(3, 2);
    issue(64'h800, 1'b0, 4, "R11 count 2");
    cfgWrite(0, 7);
    issue(64'h800, 1'b0, 4, "R11 window gran 7");
    cfgWrite(0, 0);
    cfgWrite(8, 32'h147);
    cfgWrite(12, 32'h107);
    for (int k = 0; k < 8; k++) issue(longint'(k) * 64'h100, 1'b0, 4, "R11 bridge enc");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "responses outstanding", expQ.size(), 0);
    finishRun();
  end
endmodule